// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets software on a register bus run single management transactions to Ethernet PHYs over a two-wire MDIO link, using Clause 22 framing. Software first writes a control word that enables the engine and chooses the management clock rate. It then writes one access word that holds a start flag, the direction, the PHY address, the register address and, for a write, the data. The controller sends the whole frame on MDIO, clocked by the MDC it generates. On a read it releases the line at the turnaround and shifts in the PHY's 16-bit reply.

Software finds out that a transaction has finished by reading the access word until its start flag reads zero. After a read, the acknowledge flag shows whether any PHY answered, and the data field is valid only when that flag is set. The MDIO pad is split into an output value, an output enable and an input, so the block can sit behind any tri-state or open-drain pad.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC and the MDIO output enable are low, the control word reads 0x8000_0000, and the access word reads 0.
- R2: Control word (bus_sel=0): bit 30 is the enable, and bits DIV_W-1:0 hold the divider, both read back as written. Bit 31 reads 1 when no transaction is pending or running, and 0 from launch until completion.
- R3: MDC stays low while idle. During a transaction its period is 2*(divider+1) system clocks, and a divider of 0 behaves as 1.
- R4: Access word (bus_sel=1): bit 31 is GO, bit 30 selects write (1) or read (0), bit 29 is the acknowledge, bits 25:21 are the register address, bits 20:16 are the PHY address and bits 15:0 are the data. A write with bit 31 set launches a transaction only while the enable is set. Otherwise GO stays 0 and MDC stays low.
- R5: A bus write to the access word while GO is set changes nothing and starts nothing.
- R6: A write frame sends, MSB first, 32 ones, then 01, opcode 01, the PHY address, the register address, 10, and the 16 data bits. MDIO changes only after MDC falls, so the PHY can sample it on the rising edge.
- R7: A read frame uses opcode 10. The output enable is low from the first turnaround bit to the end of the frame.
- R8: At completion GO returns to 0. On a read, the acknowledge is set when the PHY drove the second turnaround bit low, and the data field then holds the 16 bits received, first bit as bit 15.
- R9: If MDIO stays high during the second turnaround bit of a read, the acknowledge reads 0 at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 access |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The bench builds the block with DIV_W=4 and the standard 32-bit preamble. The narrow divider makes its largest setting, 15 (a 32-clock MDC period), cheap enough to use for a full read next to the 0 and 2 settings. The preamble length keeps every frame at the 64 bits a Clause 22 PHY model expects, so the PHY model can rebuild each frame it receives and answer reads at one address while ignoring another.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // access word field positions
  localparam int ACC_GO_B   = 31;
  localparam int ACC_WR_B   = 30;
  localparam int ACC_ACK_B  = 29;
  localparam int ACC_REG_LSB = 21;
  localparam int ACC_PHY_LSB = 16;
  // control word field positions
  localparam int CTL_IDLE_B = 31;
  localparam int CTL_EN_B   = 30;
  // bits that follow the preamble: start(2) op(2) phy(5) reg(5) ta(2) data(16)
  localparam int POST_PRE_BITS = 32;

  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_st_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tk,
  output logic             fall_tk
);
  logic [DIV_W-1:0] cnt_q, cnt_n, div_eff;
  logic             mdc_q, mdc_n, tick;

  always_comb begin
    div_eff = (div == '0) ? DIV_W'(1) : div;
    tick    = run && (cnt_q == div_eff);
    rise_tk = tick && !mdc_q;
    fall_tk = tick && mdc_q;
    if (!run) begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end else if (tick) begin
      cnt_n = '0;
      mdc_n = ~mdc_q;
    end else begin
      cnt_n = cnt_q + DIV_W'(1);
      mdc_n = mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int PRE_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 wr_in,
  input  logic [4:0]           phy_in,
  input  logic [4:0]           reg_in,
  input  logic [15:0]          wdata_in,
  input  logic                 rise_tk,
  input  logic                 fall_tk,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 done,
  output logic                 ack,
  output logic [15:0]          rdata,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic [$clog2(PRE_BITS+mdio_pkg::POST_PRE_BITS)-1:0] bit_idx
);
  import mdio_pkg::*;
  localparam int FRAME = PRE_BITS + POST_PRE_BITS;
  localparam int IW    = $clog2(FRAME);
  localparam logic [IW-1:0] TA_IDX   = IW'(PRE_BITS + 14);
  localparam logic [IW-1:0] ACK_IDX  = IW'(PRE_BITS + 15);
  localparam logic [IW-1:0] DAT_IDX  = IW'(PRE_BITS + 16);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME - 1);

  eng_st_t          st_q, st_n;
  logic [IW-1:0]    idx_q, idx_n;
  logic [FRAME-1:0] sh_q, sh_n;
  logic             wr_q, wr_n, ack_q, ack_n, done_q, done_n;
  logic [15:0]      rd_q, rd_n;

  always_comb begin
    st_n = st_q; idx_n = idx_q; sh_n = sh_q; wr_n = wr_q;
    ack_n = ack_q; rd_n = rd_q; done_n = 1'b0;
    case (st_q)
      ENG_IDLE: if (start) begin
        st_n  = ENG_SHIFT;
        idx_n = '0;
        sh_n  = {{PRE_BITS{1'b1}}, 2'b01, (wr_in ? 2'b01 : 2'b10),
                 phy_in, reg_in, 2'b10, wdata_in};
        wr_n  = wr_in;
        ack_n = 1'b0;
        rd_n  = '0;
      end
      default: begin
        if (rise_tk && !wr_q) begin
          if (idx_q == ACK_IDX) ack_n = ~mdio_i;
          if (idx_q >= DAT_IDX) rd_n = {rd_q[14:0], mdio_i};
        end
        if (fall_tk) begin
          if (idx_q == LAST_IDX) begin
            st_n   = ENG_IDLE;
            done_n = 1'b1;
          end else begin
            idx_n = idx_q + IW'(1);
            sh_n  = {sh_q[FRAME-2:0], 1'b0};
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ENG_IDLE; idx_q <= '0; sh_q <= '0; wr_q <= 1'b0;
      ack_q <= 1'b0; rd_q <= '0; done_q <= 1'b0;
    end else begin
      st_q <= st_n; idx_q <= idx_n; sh_q <= sh_n; wr_q <= wr_n;
      ack_q <= ack_n; rd_q <= rd_n; done_q <= done_n;
    end
  end

  assign busy    = (st_q == ENG_SHIFT);
  assign done    = done_q;
  assign ack     = ack_q;
  assign rdata   = rd_q;
  assign mdio_o  = busy && sh_q[FRAME-1];
  assign mdio_oe = busy && (wr_q || (idx_q < TA_IDX));
  assign bit_idx = idx_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W    = 8,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_pkg::*;
  localparam int IDX_W = $clog2(PRE_BITS + POST_PRE_BITS);

  logic             ctl_en_q, ctl_en_n;
  logic [DIV_W-1:0] ctl_div_q, ctl_div_n;
  logic             acc_go_q, acc_go_n, acc_wr_q, acc_wr_n, acc_ack_q, acc_ack_n;
  logic [4:0]       acc_reg_q, acc_reg_n, acc_phy_q, acc_phy_n;
  logic [15:0]      acc_dat_q, acc_dat_n;
  logic             launch, eng_busy, eng_done, eng_ack, rise_tk, fall_tk;
  logic [15:0]      eng_rdata;
  logic [IDX_W-1:0] eng_idx;

  always_comb begin
    ctl_en_n = ctl_en_q; ctl_div_n = ctl_div_q;
    acc_go_n = acc_go_q; acc_wr_n = acc_wr_q; acc_ack_n = acc_ack_q;
    acc_reg_n = acc_reg_q; acc_phy_n = acc_phy_q; acc_dat_n = acc_dat_q;
    launch = 1'b0;
    if (eng_done) begin
      acc_go_n = 1'b0;
      if (!acc_wr_q) begin
        acc_ack_n = eng_ack;
        acc_dat_n = eng_rdata;
      end
    end
    if (bus_we && !bus_sel) begin
      ctl_en_n  = bus_wdata[CTL_EN_B];
      ctl_div_n = bus_wdata[DIV_W-1:0];
    end
    if (bus_we && bus_sel && !acc_go_q &&
        (!bus_wdata[ACC_GO_B] || ctl_en_q)) begin
      launch    = bus_wdata[ACC_GO_B];
      acc_go_n  = bus_wdata[ACC_GO_B];
      acc_wr_n  = bus_wdata[ACC_WR_B];
      acc_ack_n = 1'b0;
      acc_reg_n = bus_wdata[ACC_REG_LSB +: 5];
      acc_phy_n = bus_wdata[ACC_PHY_LSB +: 5];
      acc_dat_n = bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en_q <= 1'b0; ctl_div_q <= '0;
      acc_go_q <= 1'b0; acc_wr_q <= 1'b0; acc_ack_q <= 1'b0;
      acc_reg_q <= '0; acc_phy_q <= '0; acc_dat_q <= '0;
    end else begin
      ctl_en_q <= ctl_en_n; ctl_div_q <= ctl_div_n;
      acc_go_q <= acc_go_n; acc_wr_q <= acc_wr_n; acc_ack_q <= acc_ack_n;
      acc_reg_q <= acc_reg_n; acc_phy_q <= acc_phy_n; acc_dat_q <= acc_dat_n;
    end
  end

  always_comb begin
    if (bus_sel)
      bus_rdata = {acc_go_q, acc_wr_q, acc_ack_q, 3'b000,
                   acc_reg_q, acc_phy_q, acc_dat_q};
    else
      bus_rdata = {~(acc_go_q | eng_busy), ctl_en_q,
                   {(30-DIV_W){1'b0}}, ctl_div_q};
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(ctl_div_q),
    .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  mdio_frame #(.PRE_BITS(PRE_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .start(launch),
    .wr_in(bus_wdata[ACC_WR_B]), .phy_in(bus_wdata[ACC_PHY_LSB +: 5]),
    .reg_in(bus_wdata[ACC_REG_LSB +: 5]), .wdata_in(bus_wdata[15:0]),
    .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_i(mdio_i),
    .busy(eng_busy), .done(eng_done), .ack(eng_ack), .rdata(eng_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .bit_idx(eng_idx)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int PRE_BITS = 32,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mdc,
  input logic          mdio_oe,
  input logic          eng_busy,
  input logic          eng_done,
  input logic [IW-1:0] eng_idx,
  input logic          ctl_en,
  input logic          acc_go,
  input logic          acc_wr,
  input logic [4:0]    acc_phy,
  input logic [4:0]    acc_reg
);
  localparam logic [IW-1:0] TA_IDX = IW'(PRE_BITS + 14);

  p_oe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> !mdio_oe);

  p_mdc_low_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> !mdc);

  p_mdc_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |=> $stable(mdc));

  p_no_launch_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !acc_go) |=> !acc_go);

  p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !eng_done) |=> $stable({acc_wr, acc_phy, acc_reg}));

  p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !acc_wr && eng_busy && eng_idx >= TA_IDX) |-> !mdio_oe);

  p_go_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !acc_go);
endmodule

bind mdio_master mdio_master_chk #(.PRE_BITS(PRE_BITS), .IW(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_oe(mdio_oe),
  .eng_busy(eng_busy), .eng_done(eng_done), .eng_idx(eng_idx),
  .ctl_en(ctl_en_q), .acc_go(acc_go_q), .acc_wr(acc_wr_q),
  .acc_phy(acc_phy_q), .acc_reg(acc_reg_q)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam logic [4:0] PHY_ADR = 5'd3;

  logic clk, rst_n, bus_we, bus_sel, mdc, mdio_o, mdio_oe;
  logic [31:0] bus_wdata, bus_rdata;
  logic phy_oe, phy_o;
  wire  mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_master #(.DIV_W(4), .PRE_BITS(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- PHY responder ----------------
  logic [15:0] mem [32];
  int          phy_cnt;
  logic [63:0] phy_cap, phy_frame;
  logic [4:0]  p_reg;
  bit          ta_oe_seen;

  task automatic phy_arm();
    phy_cnt = 0; phy_oe = 1'b0; phy_o = 1'b1; ta_oe_seen = 0;
  endtask

  always @(posedge mdc) begin
    if ((phy_cnt == 46 || phy_cnt == 47) && mdio_oe) ta_oe_seen = 1;
    phy_cap = {phy_cap[62:0], mdio_line};
    phy_cnt++;
    if (phy_cnt == 64) begin
      phy_frame = phy_cap;
      if (phy_cap[29:28] == 2'b01 && phy_cap[27:23] == PHY_ADR)
        mem[phy_cap[22:18]] = phy_cap[15:0];
    end
  end

  always @(negedge mdc) begin
    if (phy_cnt == 47) begin
      if (phy_cap[12:11] == 2'b10 && phy_cap[10:6] == PHY_ADR) begin
        phy_oe = 1'b1; phy_o = 1'b0; p_reg = phy_cap[5:1];
      end
    end else if (phy_cnt >= 48 && phy_cnt <= 63 && phy_oe) begin
      phy_o = mem[p_reg][63 - phy_cnt];
    end else if (phy_cnt >= 64) begin
      phy_oe = 1'b0;
    end
  end

  // ---------------- bus driver ----------------
  task automatic bus_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    bus_sel = sel;
    #1 d = bus_rdata;
  endtask

  task automatic launch(input logic wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    phy_arm();
    bus_wr(1'b1, {1'b1, wr, 1'b0, 3'b000, rg, phy, d});
  endtask

  task automatic wait_done(output logic [31:0] d);
    int n = 0;
    do begin
      bus_rd(1'b1, d);
      n++;
    end while (d[31] && n < 20000);
  endtask

  // ---------------- scoreboard ----------------
  typedef struct { logic ack; logic [15:0] data; string tag; } item_t;
  item_t exp_q[$], obs_q[$];
  event  sb_ev;

  initial begin
    forever begin
      @(sb_ev);
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        item_t e, o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        chk(o.ack == e.ack, {e.tag, " ack"}, 64'(o.ack), 64'(e.ack));
        if (e.ack)
          chk(o.data == e.data, {e.tag, " data"}, 64'(o.data), 64'(e.data));
      end
    end
  end

  task automatic do_read(input logic [4:0] phy, input logic [4:0] rg,
                         input logic eack, input logic [15:0] edata, input string tag);
    logic [31:0] d;
    item_t e, o;
    e.ack = eack; e.data = edata; e.tag = tag;
    exp_q.push_back(e);
    launch(1'b0, phy, rg, 16'h0);
    wait_done(d);
    o.ack = d[29]; o.data = d[15:0]; o.tag = tag;
    obs_q.push_back(o);
    ->sb_ev;
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    realtime t1, t2;
    for (int i = 0; i < 32; i++) mem[i] = 16'hA000 ^ 16'(i * 16'h0123);
    phy_arm();
    phy_cap = '0; phy_frame = '0; p_reg = '0;
    rst_n = 1'b0; bus_we = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    bus_rd(1'b0, d);
    chk(d == 32'h8000_0000, "R1 control", 64'(d), 64'h8000_0000);
    bus_rd(1'b1, d);
    chk(d == 32'h0, "R1 access", 64'(d), 64'h0);
    chk(!mdc && !mdio_oe, "R1 pins", 64'({mdc, mdio_oe}), 64'h0);

    // R4 launch ignored while disabled
    launch(1'b1, PHY_ADR, 5'd2, 16'h5555);
    repeat (20) @(negedge clk);
    bus_rd(1'b1, d);
    chk(!d[31], "R4 go while disabled", 64'(d[31]), 64'h0);
    chk(!mdc && phy_cnt == 0, "R4 no mdc while disabled", 64'(phy_cnt), 64'h0);

    // R2 control readback
    bus_wr(1'b0, 32'h4000_0002);
    bus_rd(1'b0, d);
    chk(d == 32'hC000_0002, "R2 control readback", 64'(d), 64'hC000_0002);

    // R6 write frame, R3 period at divider 2
    launch(1'b1, PHY_ADR, 5'd4, 16'hBEEF);
    bus_rd(1'b0, d);
    chk(!d[31], "R2 idle low while busy", 64'(d[31]), 64'h0);
    @(posedge mdc) t1 = $realtime;
    @(posedge mdc) t2 = $realtime;
    chk((t2 - t1) == 60.0, "R3 period div2", 64'(int'(t2 - t1)), 64'd60);
    wait_done(d);
    chk(phy_frame == {32'hFFFF_FFFF, 2'b01, 2'b01, PHY_ADR, 5'd4, 2'b10, 16'hBEEF},
        "R6 write frame", phy_frame,
        {32'hFFFF_FFFF, 2'b01, 2'b01, PHY_ADR, 5'd4, 2'b10, 16'hBEEF});
    chk(!d[31], "R8 go cleared after write", 64'(d[31]), 64'h0);
    repeat (10) @(negedge clk);
    chk(!mdc && !mdio_oe, "R3 mdc low after frame", 64'({mdc, mdio_oe}), 64'h0);

    // R7/R8 read back
    do_read(PHY_ADR, 5'd4, 1'b1, 16'hBEEF, "R8 read after write");
    chk(!ta_oe_seen, "R7 released at turnaround", 64'(ta_oe_seen), 64'h0);
    chk(phy_frame[29:28] == 2'b10, "R7 read opcode", 64'(phy_frame[29:28]), 64'h2);
    do_read(PHY_ADR, 5'd2, 1'b1, mem[2], "R4 disabled write left reg2");

    // R9 absent PHY
    do_read(5'd5, 5'd1, 1'b0, 16'h0, "R9 absent phy");

    // R5 write while busy ignored
    begin
      logic [15:0] e7, e9;
      e7 = mem[7]; e9 = mem[9];
      launch(1'b0, PHY_ADR, 5'd7, 16'h0);
      bus_wr(1'b1, {1'b1, 1'b1, 1'b0, 3'b000, 5'd9, PHY_ADR, 16'h1234});
      wait_done(d);
      chk(d[30] == 1'b0 && d[25:21] == 5'd7, "R5 fields kept", 64'(d[30:16]), 64'({1'b0, 4'b0, 5'd7, PHY_ADR}));
      chk(d[15:0] == e7, "R5 read result", 64'(d[15:0]), 64'(e7));
      repeat (20) @(negedge clk);
      chk(!mdc, "R5 no second frame", 64'(mdc), 64'h0);
      do_read(PHY_ADR, 5'd9, 1'b1, e9, "R5 reg9 untouched");
    end

    // R3 divider 0 acts as 1, divider 15
    bus_wr(1'b0, 32'h4000_0000);
    launch(1'b0, PHY_ADR, 5'd11, 16'h0);
    @(posedge mdc) t1 = $realtime;
    @(posedge mdc) t2 = $realtime;
    chk((t2 - t1) == 40.0, "R3 period div0", 64'(int'(t2 - t1)), 64'd40);
    wait_done(d);
    chk(d[29] && d[15:0] == mem[11], "R8 read div0", 64'(d[29:0]), 64'({1'b1, 13'b0, PHY_ADR, mem[11]}));
    bus_wr(1'b0, 32'h4000_000F);
    launch(1'b0, PHY_ADR, 5'd31, 16'h0);
    @(posedge mdc) t1 = $realtime;
    @(posedge mdc) t2 = $realtime;
    chk((t2 - t1) == 320.0, "R3 period div15", 64'(int'(t2 - t1)), 64'd320);
    wait_done(d);
    chk(d[29] && d[15:0] == mem[31], "R8 read div15", 64'(d[29:0]), 64'({1'b1, 13'b0, PHY_ADR, mem[31]}));

    #20;
    summary();
  end
endmodule